// File: doc/BRIEF.md
# Unaligned Right-Part Load Merge Unit

This unit carries out the right-hand half of an unaligned word load. It takes a base register value, a 9-bit signed offset, the destination register's current contents and a CPU byte-order flag. From these it forms the effective address and issues one word-aligned read through a valid/ready request channel. When the read data comes back, it folds the returned bytes into the low end of the destination value and leaves the upper bytes as they were. The merged word and the destination index then leave on a one-cycle write-back port.

The unit is meant to be paired with a left-part load. A program issues the two loads one after the other on the same destination register, and together they assemble a word that may sit at any byte address. The unit never rejects an address for misalignment.

The second load of such a pair may be issued in the very cycle that the first one writes back. At that point the register file copy of the destination is still stale, so the unit forwards its own write-back value in place of the supplied destination value. No stall is needed.

Top module: `rml_unit`

## Requirements
- R1: While rst is high, and in the first cycle after it falls, mreq_valid and wb_valid are 0 and issue_ready is 1.
- R2: The effective address is base_val plus offset_imm sign-extended to 32 bits. mreq_addr carries that address with bits [1:0] cleared to zero.
- R3: Each accepted issue produces exactly one request. mreq_valid and mreq_addr stay unchanged until a cycle with mreq_ready high, and mreq_valid drops after that cycle. issue_ready stays 0 from the accepted issue until the write-back.
- R4: The lane count k is the effective address bits [1:0] XOR {be_cpu, be_cpu}. wb_data bits [31-8k:0] take read-data bits [31:8k]. The remaining upper 8k bits of wb_data keep the destination value, so k=0 replaces the whole word and k=3 replaces only the low byte.
- R5: Every byte offset, 0 through 3, completes normally with a write-back. Misalignment raises no error and causes no stall.
- R6: wb_valid is high for exactly one cycle: the cycle after the cycle in which mrsp_valid is seen while a read is outstanding. wb_idx equals the dest_idx given at issue.
- R7: If an issue is accepted while wb_valid is high and dest_idx equals wb_idx, the merge uses wb_data instead of dest_old.
- R8: If an issue is accepted while wb_valid is high and dest_idx differs from wb_idx, the merge uses dest_old.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | A load is presented |
| issue_ready | output | 1 | Unit idle, load accepted this cycle if valid |
| base_val | input | 32 | Base register contents |
| offset_imm | input | 9 | Signed byte offset |
| dest_idx | input | 5 | Destination register index |
| dest_old | input | 32 | Destination register contents from the register file |
| be_cpu | input | 1 | CPU runs big-endian; inverts the lane count |
| mreq_valid | output | 1 | Read request pending |
| mreq_ready | input | 1 | Memory accepts the request |
| mreq_addr | output | 32 | Word-aligned read address |
| mrsp_valid | input | 1 | Read data valid |
| mrsp_data | input | 32 | Read data word |
| wb_valid | output | 1 | Write-back strobe |
| wb_idx | output | 5 | Write-back register index |
| wb_data | output | 32 | Merged register value |

## Verification
Several rules are checked by the assertions on every cycle: the request address stays aligned and stable while the request waits, the write-back is a single-cycle pulse that follows a response by exactly one cycle, and the unit is quiet after reset. A further assertion checks that a same-index issue during write-back captures the write-back value. The merged byte pattern for each lane count and CPU byte order can only be shown by the bench's scenarios. The same holds for effective addresses with negative offsets, and for the difference between a forwarded and a non-forwarded back-to-back pair. In those scenarios the bench computes the expected word byte by byte.

// File: rtl/rml_pkg.sv
package rml_pkg;
  localparam int XLEN   = 32;
  localparam int IMM_W  = 9;
  localparam int IDX_W  = 5;
  localparam int LANE_W = $clog2(XLEN / 8);

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} rml_state_e;

  // base plus sign-extended offset
  function automatic logic [XLEN-1:0] eff_addr(input logic [XLEN-1:0] base,
                                               input logic [IMM_W-1:0] imm);
    return base + {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
  endfunction

  // lane count from the low address bits and the CPU byte order
  function automatic logic [LANE_W-1:0] lane_count(input logic [XLEN-1:0] ea,
                                                   input logic be);
    return ea[LANE_W-1:0] ^ {LANE_W{be}};
  endfunction

  // shift memory right by k bytes into the low end, keep the old upper k bytes
  function automatic logic [XLEN-1:0] merge_right(input logic [XLEN-1:0] mem,
                                                  input logic [XLEN-1:0] old,
                                                  input logic [LANE_W-1:0] k);
    logic [XLEN-1:0] keep_lo;
    keep_lo = {XLEN{1'b1}} >> {k, 3'b000};
    return ((mem >> {k, 3'b000}) & keep_lo) | (old & ~keep_lo);
  endfunction
endpackage

// File: rtl/rml_addr_gen.sv
module rml_addr_gen
  import rml_pkg::*;
(
  input  logic [XLEN-1:0]   base_val,
  input  logic [IMM_W-1:0]  offset_imm,
  input  logic              be_cpu,
  output logic [XLEN-1:0]   word_addr,
  output logic [LANE_W-1:0] lane_k
);
  logic [XLEN-1:0] ea;

  assign ea        = eff_addr(base_val, offset_imm);
  assign word_addr = {ea[XLEN-1:LANE_W], {LANE_W{1'b0}}};
  assign lane_k    = lane_count(ea, be_cpu);
endmodule

// File: rtl/rml_fwd.sv
module rml_fwd
  import rml_pkg::*;
(
  input  logic             wb_valid,
  input  logic [IDX_W-1:0] wb_idx,
  input  logic [XLEN-1:0]  wb_data,
  input  logic [IDX_W-1:0] dest_idx,
  input  logic [XLEN-1:0]  dest_old,
  output logic             fwd_hit,
  output logic [XLEN-1:0]  old_eff
);
  assign fwd_hit = wb_valid && (wb_idx == dest_idx);
  assign old_eff = fwd_hit ? wb_data : dest_old;
endmodule

// File: rtl/rml_merge.sv
module rml_merge
  import rml_pkg::*;
(
  input  logic [XLEN-1:0]   mem_word,
  input  logic [XLEN-1:0]   old_word,
  input  logic [LANE_W-1:0] lane_k,
  output logic [XLEN-1:0]   merged
);
  assign merged = merge_right(mem_word, old_word, lane_k);
endmodule

// File: rtl/rml_unit.sv
module rml_unit
  import rml_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             issue_valid,
  output logic             issue_ready,
  input  logic [31:0]      base_val,
  input  logic [8:0]       offset_imm,
  input  logic [4:0]       dest_idx,
  input  logic [31:0]      dest_old,
  input  logic             be_cpu,
  output logic             mreq_valid,
  input  logic             mreq_ready,
  output logic [31:0]      mreq_addr,
  input  logic             mrsp_valid,
  input  logic [31:0]      mrsp_data,
  output logic             wb_valid,
  output logic [4:0]       wb_idx,
  output logic [31:0]      wb_data
);
  rml_state_e        state_q;
  logic [XLEN-1:0]   addr_q, old_q;
  logic [LANE_W-1:0] lane_q;
  logic [IDX_W-1:0]  idx_q;

  // named events for the assertions
  logic              issue_fire, req_fire, rsp_take, fwd_hit;
  logic [XLEN-1:0]   word_addr, old_eff, merged;
  logic [LANE_W-1:0] lane_k;

  assign issue_ready = (state_q == ST_IDLE);
  assign issue_fire  = issue_valid && issue_ready;
  assign mreq_valid  = (state_q == ST_REQ);
  assign mreq_addr   = addr_q;
  assign req_fire    = mreq_valid && mreq_ready;
  assign rsp_take    = (state_q == ST_WAIT) && mrsp_valid;

  rml_addr_gen u_addr (
    .base_val(base_val), .offset_imm(offset_imm), .be_cpu(be_cpu),
    .word_addr(word_addr), .lane_k(lane_k)
  );

  rml_fwd u_fwd (
    .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_data(wb_data),
    .dest_idx(dest_idx), .dest_old(dest_old),
    .fwd_hit(fwd_hit), .old_eff(old_eff)
  );

  rml_merge u_merge (
    .mem_word(mrsp_data), .old_word(old_q), .lane_k(lane_q), .merged(merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      wb_valid <= 1'b0;
    end else begin
      wb_valid <= rsp_take;
      unique case (state_q)
        ST_IDLE: if (issue_fire) state_q <= ST_REQ;
        ST_REQ:  if (req_fire)   state_q <= ST_WAIT;
        ST_WAIT: if (rsp_take)   state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (issue_fire) begin
      addr_q <= word_addr;
      lane_q <= lane_k;
      idx_q  <= dest_idx;
      old_q  <= old_eff;
    end
    if (rsp_take) begin
      wb_data <= merged;
      wb_idx  <= idx_q;
    end
  end

  // R1
  quiet_after_reset_chk: assert property (@(posedge clk)
    $past(rst) |-> (!wb_valid && !mreq_valid && issue_ready));

  // R2
  req_aligned_chk: assert property (@(posedge clk) disable iff (rst)
    mreq_valid |-> (mreq_addr[1:0] == 2'b00));

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mreq_valid && !mreq_ready) |=> (mreq_valid && $stable(mreq_addr)));

  // R3
  req_drop_chk: assert property (@(posedge clk) disable iff (rst)
    req_fire |=> !mreq_valid);

  // R6
  wb_after_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_take |=> wb_valid);

  // R6
  wb_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    wb_valid |=> !wb_valid);

  // R7
  fwd_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (issue_fire && wb_valid && (dest_idx == wb_idx)) |=> (old_q == $past(wb_data)));
endmodule

// File: tb/tb_rml_unit.sv
`timescale 1ns/1ps
module tb_rml_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        issue_valid, issue_ready;
  logic [31:0] base_val, dest_old, mreq_addr, mrsp_data, wb_data;
  logic [8:0]  offset_imm;
  logic [4:0]  dest_idx, wb_idx;
  logic        be_cpu, mreq_valid, mreq_ready, mrsp_valid, wb_valid;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  rml_unit dut (
    .clk(clk), .rst(rst), .issue_valid(issue_valid), .issue_ready(issue_ready),
    .base_val(base_val), .offset_imm(offset_imm), .dest_idx(dest_idx),
    .dest_old(dest_old), .be_cpu(be_cpu), .mreq_valid(mreq_valid),
    .mreq_ready(mreq_ready), .mreq_addr(mreq_addr), .mrsp_valid(mrsp_valid),
    .mrsp_data(mrsp_data), .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_data(wb_data)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // expected merge, built byte by byte
  function automatic logic [31:0] model(input logic [31:0] mem, input logic [31:0] old,
                                        input logic [31:0] ea, input logic be);
    int k;
    logic [31:0] r;
    k = int'(ea[1:0]);
    if (be) k = 3 - k;
    for (int i = 0; i < 4; i++)
      r[8*i +: 8] = (i < 4 - k) ? mem[8*(i+k) +: 8] : old[8*i +: 8];
    return r;
  endfunction

  // caller is at a negedge; returns at the negedge where wb_valid is high
  task automatic run_load(input logic [31:0] base, input logic [8:0] imm,
                          input logic [4:0] idx, input logic [31:0] old,
                          input logic be, input logic [31:0] mem, input int stall,
                          input logic [31:0] eff_old, input string tag);
    logic [31:0] ea, exp_addr;
    ea = base + {{23{imm[8]}}, imm};
    exp_addr = {ea[31:2], 2'b00};
    issue_valid = 1'b1; base_val = base; offset_imm = imm; dest_idx = idx;
    dest_old = old; be_cpu = be;
    @(negedge clk);
    issue_valid = 1'b0;
    chk(issue_ready == 1'b0, {"R3 busy ", tag}, 32'(issue_ready), 32'd0);
    chk(mreq_valid && mreq_addr == exp_addr, {"R2 addr ", tag}, mreq_addr, exp_addr);
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk(mreq_valid && mreq_addr == exp_addr, {"R3 hold ", tag}, mreq_addr, exp_addr);
    end
    mreq_ready = 1'b1;
    @(negedge clk);
    mreq_ready = 1'b0;
    chk(!mreq_valid, {"R3 drop ", tag}, 32'(mreq_valid), 32'd0);
    chk(!wb_valid, {"R6 early ", tag}, 32'(wb_valid), 32'd0);
    mrsp_valid = 1'b1; mrsp_data = mem;
    @(negedge clk);
    mrsp_valid = 1'b0;
    chk(wb_valid && wb_idx == idx, {"R6 wb ", tag}, {27'd0, wb_idx}, {27'd0, idx});
    chk(wb_data == model(mem, eff_old, ea, be), {"R4 data ", tag}, wb_data,
        model(mem, eff_old, ea, be));
  endtask

  task automatic t_reset();
    rst = 1'b1; issue_valid = 0; mreq_ready = 0; mrsp_valid = 0;
    base_val = 0; offset_imm = 0; dest_idx = 0; dest_old = 0; be_cpu = 0; mrsp_data = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!mreq_valid && !wb_valid && issue_ready, "R1 reset", {30'd0, mreq_valid, wb_valid}, 32'd0);
  endtask

  task automatic t_all_offsets();
    for (int b = 0; b < 4; b++) begin
      run_load(32'h0000_1000 + 32'(b), 9'd0, 5'd3, 32'hAABB_CCDD, 1'b0, 32'h1122_3344,
               0, 32'hAABB_CCDD, $sformatf("R5 le off%0d", b));
      @(negedge clk);
      chk(!wb_valid, "R6 pulse", 32'(wb_valid), 32'd0);
    end
  endtask

  task automatic t_big_endian();
    for (int b = 0; b < 4; b++) begin
      run_load(32'h0000_2000 + 32'(b), 9'd0, 5'd9, 32'hCAFE_F00D, 1'b1, 32'h8899_AABB,
               1, 32'hCAFE_F00D, $sformatf("R4 be off%0d", b));
      @(negedge clk);
    end
  endtask

  task automatic t_neg_offset();
    run_load(32'h0000_0105, 9'h1F6, 5'd7, 32'h0102_0304, 1'b0, 32'hDEAD_BEEF,
             3, 32'h0102_0304, "R2 neg imm");
    @(negedge clk);
    run_load(32'hFFFF_FFFE, 9'd3, 5'd7, 32'h5555_5555, 1'b0, 32'h1234_5678,
             0, 32'h5555_5555, "R2 wrap");
    @(negedge clk);
  endtask

  task automatic t_forward();
    logic [31:0] first;
    run_load(32'h0000_3002, 9'd0, 5'd12, 32'h1111_1111, 1'b0, 32'hA1A2_A3A4,
             0, 32'h1111_1111, "R7 first");
    first = wb_data;
    run_load(32'h0000_3005, 9'd0, 5'd12, 32'h1111_1111, 1'b0, 32'hB1B2_B3B4,
             0, first, "R7 forwarded");
    run_load(32'h0000_3007, 9'd0, 5'd13, 32'h2222_2222, 1'b0, 32'hC1C2_C3C4,
             0, 32'h2222_2222, "R8 other idx");
    @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_all_offsets();
    t_big_endian();
    t_neg_offset();
    t_forward();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule